// File: doc/BRIEF.md
# Interrupt and DMA Request Router

This block keeps the pending-request register and the request-mask register of a memory-card host controller. The data path and the command sequencer raise and retire individual request bits with one-cycle set and clear pulses. Software programs the mask through a register write port. The block folds the pending, unmasked requests into one processor interrupt line.

When the command configuration enables DMA, the two FIFO service requests no longer reach the processor. Each one drives its own DMA request line instead: one line for receive and one for transmit. The block also owns the card-clock state. A start strobe turns the clock-enabled status on. A stop strobe turns it off, raises the clock-off request and emits a one-cycle abort to the transfer logic.

All outputs are registered. Each output reflects the inputs that were presented in the cycle before the clock edge.

Top module: `irq_dma_router`

## Requirements
- R1: When reset (synchronous, active-low) is applied, every request bit, every mask bit, the interrupt, both DMA request lines, the clock-enabled status and the abort output are zero.
- R2: The request vector has 13 bits. Bit 0 is data done, bit 1 is program done, bit 2 is command end and bit 3 is stop command. Bit 4 is clock off, bit 5 is receive FIFO service and bit 6 is transmit FIFO service. Bit 7 is the timer interrupt, bit 8 is data error, bit 9 is response error and bit 10 is read stalled. Bits 11 and 12 are the card interrupt and the card acknowledge.
- R3: A set pulse on a bit makes that bit 1 after the next edge, and a clear pulse makes it 0. When a bit gets both pulses in the same cycle, the set pulse wins. Bits with no pulse hold their value.
- R4: A mask write stores bits 12..0 of the 32-bit write data, and bits 31..13 are dropped. A write appears on `mask_out` after the next edge.
- R5: `cpu_irq` is 1 after an edge exactly when some request bit is 1 and its mask bit is 0. The request and mask values are the ones in force after that edge.
- R6: While `dma_en` is 1, request bits 5 and 6 are treated as masked for `cpu_irq`.
- R7: While `dma_en` is 1, `rx_dma_req` follows request bit 5 and `tx_dma_req` follows request bit 6. Both update at the same edge as the request bits.
- R8: While `dma_en` is 0, `rx_dma_req` and `tx_dma_req` hold their last value, whatever the requests do.
- R9: A clock-start strobe sets `clk_enabled` and clears request bit 4. This takes priority over any set pulse on bit 4 in the same cycle.
- R10: A clock-stop strobe clears `clk_enabled`, sets request bit 4 and drives `xfer_abort` high for exactly the following cycle.
- R11: When start and stop are strobed in the same cycle, the stop wins. `clk_enabled` ends at 0, bit 4 ends at 1 and the abort fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_set | input | 13 | One-cycle set pulses, one per request bit |
| req_clr | input | 13 | One-cycle clear pulses, one per request bit |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 32 | Mask write data; only bits 12..0 are kept |
| dma_en | input | 1 | DMA-enable level from the command configuration |
| clk_start | input | 1 | Card clock start strobe |
| clk_stop | input | 1 | Card clock stop strobe |
| req_out | output | 13 | Pending request vector |
| mask_out | output | 13 | Mask register |
| cpu_irq | output | 1 | Processor interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| clk_enabled | output | 1 | Clock-enabled status |
| xfer_abort | output | 1 | One-cycle abort to the transfer logic |

## Verification
The bench builds the block with its default parameters: 13 request bits, with the clock-off, receive and transmit bits at positions 4, 5 and 6. At those values the directed cases can reach every bit that the DMA routing and the clock logic touch. These cases cover:
- collisions between set and clear pulses, and between a strobe and a pulse on the same bit;
- mask writes with the upper bits set;
- the hold behaviour of the DMA lines while DMA is off.

A long pseudo-random stretch then mixes sparse pulses, mask writes, DMA toggling and clock strobes. A behavioural model checks every output on every cycle.

// File: rtl/mir_pkg.sv
// Package: shared parameters and the decoded clock-command type for the
// interrupt and DMA request router. Assumes one clock domain.
package mir_pkg;
    localparam int unsigned DEF_NREQ       = 13;
    localparam int unsigned DEF_WR_W       = 32;
    localparam int unsigned DEF_CLKOFF_BIT = 4;
    localparam int unsigned DEF_RX_BIT     = 5;
    localparam int unsigned DEF_TX_BIT     = 6;

    // Decoded card-clock command for one cycle; HALT outranks RUN.
    typedef enum logic [1:0] {
        CLK_HOLD = 2'd0,
        CLK_RUN  = 2'd1,
        CLK_HALT = 2'd2
    } clk_cmd_e;
endpackage

// File: rtl/mir_clk_ctl.sv
// Card-clock control: decodes start/stop strobes into one command (stop
// wins), keeps the clock-enabled status and issues a one-cycle abort.
// Assumes strobes are single-cycle pulses; synchronous active-low reset.
module mir_clk_ctl
    import mir_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     stop_i,
    output clk_cmd_e cmd_o,
    output logic     clk_en_o,
    output logic     abort_o
);
    logic clk_en_q;
    logic abort_q;

    // Decode the strobes; the stop is handled after the start so it wins.
    always_comb begin
        cmd_o = CLK_HOLD;
        if (start_i) cmd_o = CLK_RUN;
        if (stop_i)  cmd_o = CLK_HALT;
    end

    // Hold the clock-enabled status and register the abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            abort_q <= (cmd_o == CLK_HALT);
            case (cmd_o)
                CLK_RUN:  clk_en_q <= 1'b1;
                CLK_HALT: clk_en_q <= 1'b0;
                default:  clk_en_q <= clk_en_q;
            endcase
        end
    end

    assign clk_en_o = clk_en_q;
    assign abort_o  = abort_q;

    // R9: a lone start turns the clock on.
    a_r9_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i) |=> clk_en_o);
    // R10: a stop turns the clock off and aborts for one cycle.
    a_r10_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!clk_en_o && abort_o));
    // R10: the abort never lasts beyond the cycle after a stop.
    a_r10_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_i |=> !abort_o);
endmodule

// File: rtl/mir_req_bank.sv
// Request bank: one flop per request bit with set/clear pulses (set wins).
// The clock-off bit is also driven by the clock command, which outranks
// the pulses. Exposes the next-state vector so outputs can be registered
// in the same edge. Synchronous active-low reset.
module mir_req_bank
    import mir_pkg::*;
#(
    parameter int unsigned NREQ       = DEF_NREQ,
    parameter int unsigned CLKOFF_BIT = DEF_CLKOFF_BIT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] set_i,
    input  logic [NREQ-1:0] clr_i,
    input  clk_cmd_e        cmd_i,
    output logic [NREQ-1:0] req_d_o,
    output logic [NREQ-1:0] req_q_o
);
    localparam logic [NREQ-1:0] CLKOFF_MASK = NREQ'(1) << CLKOFF_BIT;

    logic [NREQ-1:0] req_q;
    logic [NREQ-1:0] req_d;

    for (genvar i = 0; i < NREQ; i++) begin : g_bit
        if (i == CLKOFF_BIT) begin : g_clkoff
            // Next value of the clock-off bit: clock command first, then pulses.
            always_comb begin
                if (cmd_i == CLK_HALT)      req_d[i] = 1'b1;
                else if (cmd_i == CLK_RUN)  req_d[i] = 1'b0;
                else if (set_i[i])          req_d[i] = 1'b1;
                else if (clr_i[i])          req_d[i] = 1'b0;
                else                        req_d[i] = req_q[i];
            end
        end else begin : g_plain
            // Next value of an ordinary request bit: set outranks clear.
            always_comb begin
                if (set_i[i])      req_d[i] = 1'b1;
                else if (clr_i[i]) req_d[i] = 1'b0;
                else               req_d[i] = req_q[i];
            end
        end
    end

    // Store the request vector.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end

    assign req_d_o = req_d;
    assign req_q_o = req_q;

    // R3: every pulsed set (outside the clock-off bit) is visible next cycle.
    a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        |(set_i & ~CLKOFF_MASK) |=>
        ((req_q & $past(set_i) & ~CLKOFF_MASK) == ($past(set_i) & ~CLKOFF_MASK)));
    // R3: a clear without a set removes the bit.
    a_r3_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
        |(clr_i & ~set_i & ~CLKOFF_MASK) |=>
        ((req_q & $past(clr_i & ~set_i) & ~CLKOFF_MASK) == '0));
    // R9/R11: clock commands own the clock-off bit.
    a_r11_halt_sets_clkoff: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CLK_HALT) |=> req_q[CLKOFF_BIT]);
    a_r9_run_clears_clkoff: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CLK_RUN) |=> !req_q[CLKOFF_BIT]);
endmodule

// File: rtl/mir_mask_reg.sv
// Mask register: captures the low NREQ bits of a wider write word.
// Exposes the next-state value for same-edge output registration.
// Synchronous active-low reset.
module mir_mask_reg
    import mir_pkg::*;
#(
    parameter int unsigned NREQ = DEF_NREQ,
    parameter int unsigned WR_W = DEF_WR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [WR_W-1:0] wr_data_i,
    output logic [NREQ-1:0] mask_d_o,
    output logic [NREQ-1:0] mask_q_o
);
    logic [NREQ-1:0] mask_q;

    // Select the written value or keep the stored one.
    always_comb mask_d_o = wr_en_i ? wr_data_i[NREQ-1:0] : mask_q;

    // Store the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d_o;
    end

    assign mask_q_o = mask_q;

    // R4: upper write bits never reach the register.
    a_r4_upper_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && |wr_data_i[WR_W-1:NREQ]) |=>
        (mask_q == $past(wr_data_i[NREQ-1:0])));
    // R4: without a write the mask holds.
    a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mask_q));
endmodule

// File: rtl/mir_route.sv
// Output router: forms the processor interrupt from next-state requests
// and mask, hiding the two FIFO service bits when DMA is enabled, and
// drives the DMA request lines from those bits (held while DMA is off).
// Synchronous active-low reset.
module mir_route
    import mir_pkg::*;
#(
    parameter int unsigned NREQ   = DEF_NREQ,
    parameter int unsigned RX_BIT = DEF_RX_BIT,
    parameter int unsigned TX_BIT = DEF_TX_BIT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_d_i,
    input  logic [NREQ-1:0] mask_d_i,
    input  logic            dma_en_i,
    output logic            irq_o,
    output logic            rx_o,
    output logic            tx_o
);
    localparam logic [NREQ-1:0] DMA_BITS = (NREQ'(1) << RX_BIT) | (NREQ'(1) << TX_BIT);

    logic [NREQ-1:0] eff_mask;
    logic            irq_q;
    logic            rx_q;
    logic            tx_q;

    // Widen the mask over the FIFO service bits while DMA owns them.
    always_comb eff_mask = dma_en_i ? (mask_d_i | DMA_BITS) : mask_d_i;

    // Register the interrupt and the DMA lines (lines hold while DMA is off).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            rx_q  <= 1'b0;
            tx_q  <= 1'b0;
        end else begin
            irq_q <= |(req_d_i & ~eff_mask);
            if (dma_en_i) begin
                rx_q <= req_d_i[RX_BIT];
                tx_q <= req_d_i[TX_BIT];
            end
        end
    end

    assign irq_o = irq_q;
    assign rx_o  = rx_q;
    assign tx_o  = tx_q;

    // R6: with DMA on, FIFO service bits alone cannot raise the interrupt.
    a_r6_dma_hides_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en_i && ((req_d_i & ~mask_d_i & ~DMA_BITS) == '0)) |=> !irq_o);
    // R5: an unmasked non-FIFO request always raises the interrupt.
    a_r5_unmasked_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_d_i & ~mask_d_i & ~DMA_BITS)) |=> irq_o);
    // R8: DMA lines are frozen while DMA is disabled.
    a_r8_dma_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en_i |=> ($stable(rx_o) && $stable(tx_o)));
    // R7: with DMA on, the lines track the FIFO service bits.
    a_r7_dma_follow: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en_i |=> ((rx_o == $past(req_d_i[RX_BIT])) && (tx_o == $past(req_d_i[TX_BIT]))));
endmodule

// File: rtl/irq_dma_router.sv
// Top: interrupt and DMA request router of a memory-card host controller.
// Holds the request and mask registers and the card-clock status, and
// drives one processor interrupt plus receive/transmit DMA requests.
// Assumes all pulses are single-cycle and synchronous to clk.
module irq_dma_router
    import mir_pkg::*;
#(
    parameter int unsigned NREQ       = DEF_NREQ,
    parameter int unsigned WR_W       = DEF_WR_W,
    parameter int unsigned CLKOFF_BIT = DEF_CLKOFF_BIT,
    parameter int unsigned RX_BIT     = DEF_RX_BIT,
    parameter int unsigned TX_BIT     = DEF_TX_BIT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_set,
    input  logic [NREQ-1:0] req_clr,
    input  logic            mask_wr_en,
    input  logic [WR_W-1:0] mask_wr_data,
    input  logic            dma_en,
    input  logic            clk_start,
    input  logic            clk_stop,
    output logic [NREQ-1:0] req_out,
    output logic [NREQ-1:0] mask_out,
    output logic            cpu_irq,
    output logic            rx_dma_req,
    output logic            tx_dma_req,
    output logic            clk_enabled,
    output logic            xfer_abort
);
    clk_cmd_e        clk_cmd;
    logic [NREQ-1:0] req_next;
    logic [NREQ-1:0] mask_next;

    mir_clk_ctl u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (clk_start),
        .stop_i   (clk_stop),
        .cmd_o    (clk_cmd),
        .clk_en_o (clk_enabled),
        .abort_o  (xfer_abort)
    );

    mir_req_bank #(.NREQ(NREQ), .CLKOFF_BIT(CLKOFF_BIT)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (req_set),
        .clr_i   (req_clr),
        .cmd_i   (clk_cmd),
        .req_d_o (req_next),
        .req_q_o (req_out)
    );

    mir_mask_reg #(.NREQ(NREQ), .WR_W(WR_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (mask_wr_en),
        .wr_data_i (mask_wr_data),
        .mask_d_o  (mask_next),
        .mask_q_o  (mask_out)
    );

    mir_route #(.NREQ(NREQ), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_d_i  (req_next),
        .mask_d_i (mask_next),
        .dma_en_i (dma_en),
        .irq_o    (cpu_irq),
        .rx_o     (rx_dma_req),
        .tx_o     (tx_dma_req)
    );

    // R11: simultaneous start and stop leave the clock off with clock-off pending.
    a_r11_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_start && clk_stop) |=> (!clk_enabled && req_out[CLKOFF_BIT] && xfer_abort));
    // R1: one cycle after reset is released, everything is still clear.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (req_out == '0 && mask_out == '0 && !cpu_irq && !rx_dma_req &&
                    !tx_dma_req && !clk_enabled && !xfer_abort));
endmodule

// File: tb/sim_irq_dma_router.sv
// Bench: behavioural reference model updated at each rising edge and
// compared against every output at the following falling edge.
module sim_irq_dma_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] req_set = '0, req_clr = '0;
    logic        mask_wr_en = 1'b0;
    logic [31:0] mask_wr_data = '0;
    logic        dma_en = 1'b0, clk_start = 1'b0, clk_stop = 1'b0;
    logic [12:0] req_out, mask_out;
    logic        cpu_irq, rx_dma_req, tx_dma_req, clk_enabled, xfer_abort;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // model state
    logic [12:0] m_req = '0, m_mask = '0;
    logic        m_irq = 0, m_rx = 0, m_tx = 0, m_ce = 0, m_ab = 0;

    always #10 clk = ~clk;

    irq_dma_router u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(req_out == m_req, "R3 request vector", req_out, m_req);
        chk(mask_out == m_mask, "R4 mask register", mask_out, m_mask);
        chk(cpu_irq == m_irq, dma_en ? "R6 irq with dma" : "R5 irq", cpu_irq, m_irq);
        chk(rx_dma_req == m_rx, dma_en ? "R7 rx dma" : "R8 rx hold", rx_dma_req, m_rx);
        chk(tx_dma_req == m_tx, dma_en ? "R7 tx dma" : "R8 tx hold", tx_dma_req, m_tx);
        chk(clk_enabled == m_ce, "R9 clk_enabled", clk_enabled, m_ce);
        chk(xfer_abort == m_ab, "R10 abort", xfer_abort, m_ab);
    endtask

    // one cycle: drive after falling edge, update model at rising edge, compare
    task automatic step(input logic [12:0] s, input logic [12:0] c, input bit w,
                        input logic [31:0] wd, input bit d, input bit st, input bit sp);
        logic [12:0] nreq, eff;
        req_set = s; req_clr = c; mask_wr_en = w; mask_wr_data = wd;
        dma_en = d; clk_start = st; clk_stop = sp;
        @(posedge clk);
        if (!rst_n) begin
            m_req = '0; m_mask = '0; m_irq = 0; m_rx = 0; m_tx = 0; m_ce = 0; m_ab = 0;
        end else begin
            nreq = (m_req & ~c) | s;
            if (st) nreq[4] = 1'b0;
            if (sp) nreq[4] = 1'b1;
            if (w) m_mask = wd[12:0];
            eff = m_mask | (d ? 13'h0060 : 13'h0000);
            m_req = nreq;
            m_irq = |(nreq & ~eff);
            if (d) begin m_rx = nreq[5]; m_tx = nreq[6]; end
            if (st) m_ce = 1'b1;
            if (sp) m_ce = 1'b0;
            m_ab = sp;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input bit d);
        step('0, '0, 0, '0, d, 0, 0);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        step(13'h1fff, '0, 1, 32'hffff_ffff, 1, 1, 0);
        step('0, '0, 0, '0, 0, 0, 0);
        rst_n = 1'b1;
        chk(req_out == 0 && mask_out == 0 && !cpu_irq && !rx_dma_req && !tx_dma_req
            && !clk_enabled && !xfer_abort, "R1 reset state", {req_out, mask_out}, 0);

        // R2/R5: each bit raises irq alone, then clears
        for (int i = 0; i < 13; i++) begin
            step(13'(1) << i, '0, 0, '0, 0, 0, 0);
            chk(cpu_irq && req_out == (13'(1) << i), "R2 bit position", req_out, 13'(1) << i);
            step('0, 13'(1) << i, 0, '0, 0, 0, 0);
        end
        // R3: set and clear together -> set wins
        step(13'h0a01, 13'h0a01, 0, '0, 0, 0, 0);
        chk(req_out == 13'h0a01, "R3 set beats clear", req_out, 13'h0a01);
        step('0, 13'h1fff, 0, '0, 0, 0, 0);
        // R4: upper bits dropped
        step('0, '0, 1, 32'hffff_e005, 0, 0, 0);
        chk(mask_out == 13'h0005, "R4 upper bits dropped", mask_out, 13'h0005);
        // R5: masked request stays quiet, unmasked one fires
        step(13'h0001, '0, 0, '0, 0, 0, 0);
        chk(!cpu_irq, "R5 masked request silent", cpu_irq, 0);
        step(13'h0002, '0, 0, '0, 0, 0, 0);
        chk(cpu_irq, "R5 unmasked request fires", cpu_irq, 1);
        step('0, 13'h1fff, 1, 32'h0, 0, 0, 0);
        // R6/R7: dma on, fifo bits go to dma lines only
        step(13'h0020, '0, 0, '0, 1, 0, 0);
        chk(!cpu_irq && rx_dma_req && !tx_dma_req, "R6 rx routed to dma", {cpu_irq, rx_dma_req, tx_dma_req}, 3'b010);
        step(13'h0040, 13'h0020, 0, '0, 1, 0, 0);
        chk(!cpu_irq && !rx_dma_req && tx_dma_req, "R7 tx routed to dma", {cpu_irq, rx_dma_req, tx_dma_req}, 3'b001);
        // R8: dma off: lines hold while requests change
        step(13'h0020, 13'h0040, 0, '0, 0, 0, 0);
        chk(!rx_dma_req && tx_dma_req && cpu_irq, "R8 lines hold, irq resumes", {cpu_irq, rx_dma_req, tx_dma_req}, 3'b101);
        step('0, 13'h1fff, 0, '0, 0, 0, 0);
        chk(tx_dma_req, "R8 tx held after clear", tx_dma_req, 1);
        step('0, '0, 0, '0, 1, 0, 0);
        // R9: start beats a set pulse on clock-off bit
        step(13'h0010, '0, 0, '0, 0, 1, 0);
        chk(clk_enabled && !req_out[4], "R9 start clears clock-off", {clk_enabled, req_out[4]}, 2'b10);
        // R10: stop
        step('0, 13'h0010, 0, '0, 0, 0, 1);
        chk(!clk_enabled && req_out[4] && xfer_abort, "R10 stop", {clk_enabled, req_out[4], xfer_abort}, 3'b011);
        idle(0);
        chk(!xfer_abort, "R10 abort one cycle", xfer_abort, 0);
        step('0, '0, 0, '0, 0, 1, 0);
        // R11: both strobes -> stop wins
        step('0, '0, 0, '0, 0, 1, 1);
        chk(!clk_enabled && req_out[4] && xfer_abort, "R11 stop wins", {clk_enabled, req_out[4], xfer_abort}, 3'b011);

        // mixed pseudo-random traffic
        for (int k = 0; k < 600; k++) begin
            step(13'($urandom & $urandom & $urandom), 13'($urandom & $urandom),
                 ($urandom % 8) == 0, $urandom, ($urandom % 4) != 0,
                 ($urandom % 10) == 0, ($urandom % 13) == 0);
        end
        // R1: reset mid-run
        rst_n = 1'b0;
        step(13'h1fff, '0, 0, '0, 1, 1, 0);
        rst_n = 1'b1;
        chk(req_out == 0 && !clk_enabled && !cpu_irq, "R1 reset mid-run", req_out, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule